// File: doc/BRIEF.md
# Addressable Scan State Array

This block is a bank of state bits that a tester reaches one at a time by address, the way a memory word is reached, rather than by shifting the whole bank through a serial chain. In functional operation the bank acts as an ordinary register: every bit captures its own functional data input on each clock edge. In test operation the functional inputs are shut off and the bank is frozen, except for the single bit named by the scan address. That bit is the only one that receives the scan clock. It loads the serial scan input when the scan clock enable is high.

Observation works the same way. Each bit drives a per-cell observe line that is forced to 1 unless the bit is addressed, in which case it carries the stored value. The scan output is the AND of all the observe lines, so it shows the content of the addressed bit. An address beyond the last bit selects nothing. The scan output then reads 1 and a scan clock writes no bit. The address arrives in parallel, and reading the scan output is combinational from the current address.

Top module: `addr_scan_array`

## Requirements
- R1: While rst_n is low, every bit of func_q is 0.
- R2: With test_mode at 0, each clock edge loads func_d into func_q for all bits, and scan_in, scan_addr and scan_ck_en have no effect on func_q.
- R3: With test_mode at 1 and scan_ck_en at 1, the clock edge writes scan_in into bit scan_addr of func_q, and every other bit keeps its value.
- R4: With test_mode at 1 and scan_ck_en at 0, a clock edge leaves every bit of func_q unchanged.
- R5: When scan_addr is below N, scan_out equals func_q[scan_addr] in the same cycle, without waiting for a clock edge.
- R6: When scan_addr is N or greater, scan_out is 1, and a scan clock enable in test mode changes no bit.
- R7: In test mode func_d has no effect on func_q.
- R8: At most one cell is selected at a time. Every cell that is not selected drives a 1 onto its observe line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the functional and scan loads |
| rst_n | input | 1 | Asynchronous active-low reset; clears all bits |
| test_mode | input | 1 | 1 selects addressed scan access; 0 selects functional loading |
| scan_ck_en | input | 1 | Gates the scan clock to the addressed bit in test mode |
| scan_addr | input | AW = ceil(log2 N) | Index of the bit being written or observed |
| scan_in | input | 1 | Serial scan data written to the addressed bit |
| scan_out | output | 1 | Content of the addressed bit; 1 when the address is out of range |
| func_d | input | N | Functional data, one bit per cell |
| func_q | output | N | Stored state of all cells |

## Verification
The hardest cases to reach are the ones where a scan write must leave the unaddressed bits untouched, and where an out-of-range address must neither show data nor write any. The stimulus first writes each bit in turn with a mix of 0 and 1 values. It then holds func_d at the complement of the stored contents, so that any leak from the functional path would flip bits. Next it drives every unused address code with scan_in at 0 and the scan clock enabled, while the bank holds a known pattern of 1 bits. A stray write would clear one of those bits and a stray read would show a 0.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Address width for an array of n cells (at least one bit).
  function automatic int addr_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // True when the address names an existing cell.
  function automatic bit addr_in_range(input int unsigned a, input int unsigned n);
    return a < n;
  endfunction

  // Per-cell observe value: a cell not selected contributes a logical one.
  function automatic logic obs_value(input logic selected, input logic stored);
    return selected ? stored : 1'b1;
  endfunction

endpackage

// File: rtl/ras_decoder.sv
module ras_decoder #(
  parameter int N  = 12,
  parameter int AW = ras_pkg::addr_bits(N)
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel
);

  // One comparator per cell; codes past N-1 match nothing.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign sel[i] = (addr == AW'(i));
  end

endmodule

// File: rtl/ras_cell.sv
module ras_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic scan_ck_en,
  input  logic sel,
  input  logic scan_in,
  input  logic d,
  output logic q,
  output logic obs
);

  logic scan_clk_hit;
  logic func_load;

  // Only the addressed cell receives the scan clock, and only in test mode.
  assign scan_clk_hit = test_mode & scan_ck_en & sel;
  assign func_load    = ~test_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= 1'b0;
    else if (func_load)    q <= d;
    else if (scan_clk_hit) q <= scan_in;
  end

  assign obs = ras_pkg::obs_value(sel, q);

endmodule

// File: rtl/ras_wired_and.sv
module ras_wired_and #(
  parameter int N = 12
) (
  input  logic [N-1:0] obs,
  output logic         y
);

  // Running AND chain models the shared open-drain observe line.
  logic [N:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < N; i++) begin : g_and
    assign chain[i+1] = chain[i] & obs[i];
  end
  assign y = chain[N];

endmodule

// File: rtl/addr_scan_array.sv
module addr_scan_array #(
  parameter int N = 12,
  localparam int AW = ras_pkg::addr_bits(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          scan_ck_en,
  input  logic [AW-1:0] scan_addr,
  input  logic          scan_in,
  output logic          scan_out,
  input  logic [N-1:0]  func_d,
  output logic [N-1:0]  func_q
);

  // Named internal events for the checker.
  logic [N-1:0] sel_vec;
  logic [N-1:0] obs_vec;

  ras_decoder #(.N(N), .AW(AW)) u_dec (
    .addr (scan_addr),
    .sel  (sel_vec)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    ras_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .test_mode  (test_mode),
      .scan_ck_en (scan_ck_en),
      .sel        (sel_vec[i]),
      .scan_in    (scan_in),
      .d          (func_d[i]),
      .q          (func_q[i]),
      .obs        (obs_vec[i])
    );
  end

  ras_wired_and #(.N(N)) u_and (
    .obs (obs_vec),
    .y   (scan_out)
  );

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int N  = 12,
  parameter int AW = ras_pkg::addr_bits(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          test_mode,
  input logic          scan_ck_en,
  input logic [AW-1:0] scan_addr,
  input logic          scan_in,
  input logic          scan_out,
  input logic [N-1:0]  func_d,
  input logic [N-1:0]  func_q,
  input logic [N-1:0]  sel_vec,
  input logic [N-1:0]  obs_vec
);

  logic [N-1:0] q_at_addr;
  logic         addr_ok;
  assign q_at_addr = func_q >> scan_addr;
  assign addr_ok   = 32'(scan_addr) < N;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> func_q == '0); // R1

  AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> func_q == $past(func_d)); // R2

  AST_SCAN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && scan_ck_en && (sel_vec != '0))
      |=> ((func_q & $past(sel_vec)) != '0) == $past(scan_in)); // R3

  AST_SCAN_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && scan_ck_en)
      |=> (func_q & ~$past(sel_vec)) == ($past(func_q) & ~$past(sel_vec))); // R3

  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !scan_ck_en) |=> $stable(func_q)); // R4

  AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ok |-> scan_out == q_at_addr[0]); // R5

  AST_OOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> (scan_out && sel_vec == '0)); // R6

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec)); // R8

  AST_IDLE_OBS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_vec | sel_vec) == '1); // R8

endmodule

bind addr_scan_array ras_checker #(.N(N), .AW(AW)) u_ras_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .test_mode  (test_mode),
  .scan_ck_en (scan_ck_en),
  .scan_addr  (scan_addr),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .func_d     (func_d),
  .func_q     (func_q),
  .sel_vec    (sel_vec),
  .obs_vec    (obs_vec)
);

// File: tb/addr_scan_array_bench.sv
module addr_scan_array_bench;
  localparam int N  = 12;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          test_mode;
  logic          scan_ck_en;
  logic [AW-1:0] scan_addr;
  logic          scan_in;
  logic          scan_out;
  logic [N-1:0]  func_d;
  logic [N-1:0]  func_q;

  logic [N-1:0] exp_q;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  addr_scan_array #(.N(N)) u_addr_scan_array (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_ck_en(scan_ck_en),
    .scan_addr(scan_addr), .scan_in(scan_in), .scan_out(scan_out),
    .func_d(func_d), .func_q(func_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One clock edge; inputs driven and outputs sampled 2 ns after it.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; test_mode = 1'b0; scan_ck_en = 1'b0;
    scan_addr = '0; scan_in = 1'b0; func_d = '1;
    step(); step();
    chk("R1 reset clears bits", 32'(func_q), 32'h0);
    rst_n = 1'b1;
    exp_q = '0;
    step();
  endtask

  task automatic t_normal_load();
    logic [N-1:0] pats [3] = '{12'hA5C, 12'h3F0, 12'hFFF};
    test_mode = 1'b0;
    foreach (pats[k]) begin
      func_d = pats[k];
      scan_ck_en = 1'b1; scan_in = k[0]; scan_addr = AW'(k);
      step();
      exp_q = pats[k];
      chk("R2 functional load", 32'(func_q), 32'(exp_q));
    end
    scan_ck_en = 1'b0;
  endtask

  task automatic t_scan_write();
    test_mode = 1'b1;
    func_d = 12'h000;
    step();
    chk("R7 entering test mode keeps state", 32'(func_q), 32'(exp_q));
    for (int i = 0; i < N; i++) begin
      scan_addr = AW'(i);
      scan_in = (i % 3 == 0);
      func_d = ~exp_q;
      scan_ck_en = 1'b1;
      step();
      exp_q[i] = (i % 3 == 0);
      chk("R3 addressed scan write", 32'(func_q), 32'(exp_q));
    end
    scan_ck_en = 1'b0;
  endtask

  task automatic t_hold();
    test_mode = 1'b1; scan_ck_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      scan_addr = AW'(i + 2);
      scan_in = ~exp_q[i + 2];
      func_d = ~exp_q;
      step();
      chk("R4 hold without scan clock", 32'(func_q), 32'(exp_q));
    end
    chk("R7 func_d ignored in test mode", 32'(func_q), 32'(exp_q));
  endtask

  task automatic t_read();
    for (int i = 0; i < N; i++) begin
      scan_addr = AW'(i);
      #1;
      chk("R5 scan_out shows addressed bit", 32'(scan_out), 32'(exp_q[i]));
    end
    // Flip bit 5, then read it back without changing the address afterwards.
    scan_addr = AW'(5); scan_in = ~exp_q[5]; scan_ck_en = 1'b1;
    step();
    scan_ck_en = 1'b0;
    exp_q[5] = ~exp_q[5];
    chk("R5 read after write", 32'(scan_out), 32'(exp_q[5]));
  endtask

  task automatic t_out_of_range();
    test_mode = 1'b1;
    exp_q = 12'hFF0;
    for (int i = 0; i < N; i++) begin
      scan_addr = AW'(i); scan_in = exp_q[i]; scan_ck_en = 1'b1;
      step();
    end
    chk("R6 preload pattern", 32'(func_q), 32'(exp_q));
    for (int a = N; a < (1 << AW); a++) begin
      scan_addr = AW'(a); scan_in = 1'b0; scan_ck_en = 1'b1;
      #1;
      chk("R6 out-of-range reads one", 32'(scan_out), 32'h1);
      step();
      chk("R6 out-of-range writes nothing", 32'(func_q), 32'(exp_q));
    end
    scan_ck_en = 1'b0;
  endtask

  task automatic t_back_to_normal();
    test_mode = 1'b0; func_d = 12'h5A3; scan_ck_en = 1'b1; scan_in = 1'b1;
    scan_addr = AW'(0);
    step();
    chk("R2 functional load after test", 32'(func_q), 32'h5A3);
    #1;
    chk("R5 read in functional mode", 32'(scan_out), 32'h1);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal_load();
    t_scan_write();
    t_hold();
    t_read();
    t_out_of_range();
    t_back_to_normal();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule